// File: doc/BRIEF.md
# IO Address Translation Cache

This block turns 32-bit DMA addresses issued by devices into real memory addresses. It keeps two tables that software loads. The first is a 16-entry segment table: one entry per 256 MB region of IO space, each giving a page size and the base of a page table in memory. The second is a direct-mapped cache of page-table entries (PTEs). Each PTE slot holds a 64-bit value and a separate tag.

On a lookup, the block uses the segment entry to work out where the PTE for the address would sit in memory. It hashes that PTE address into a cache slot and builds the expected tag from it. It then compares that tag with the stored one. A match yields the real address, assembled from the cached real page number and the in-page offset. It also yields a protection verdict for the requested access direction. Walking the tables in memory on a miss is not part of this block. Software must load every translation beforehand through the write port.

The lookup is a two-stage pipeline that accepts one address per cycle. A PTE slot is updated with two writes: the value first and the tag second. The first write drops the slot's valid state, so a lookup that falls between the two writes cannot hit on a half-written slot.

Top module: `io_xlate_cache`

## Requirements
- R1: The segment entry is chosen by lookup address bits [31:28]. A segment write (`wr_kind`=0) at `wr_idx[3:0]` stores these fields from `wr_data`: the valid flag from bit 63, the page-table base from bits [33:12], and the size code from bits [2:0].
- R2: The page number is lookup address bits [27:0] shifted right by 10 + 2×code. Codes 1, 3, 5 and 7 select 4 KB, 64 KB, 1 MB and 16 MB pages.
- R3: The PTE address (34 bits) is {base, 12'b0} plus ((page number × 8) AND 0x7FFF8).
- R4: The expected tag is {PTE address [33:18], PTE address [11:3]} (25 bits). A tag write (`wr_kind`=2) stores `wr_data[24:0]` as the tag and `wr_data[25]` as the slot's valid flag. A lookup hits only if the segment is valid, the slot is valid, and the stored tag equals the expected one.
- R5: The 6-bit base index is PTE address [8:3] XOR the bit-reversed PTE address [17:12], with bit 17 landing on index bit 0 and bit 12 on index bit 5. With `IDX_W`=8, index bits [7:6] are PTE address [15:14].
- R6: On a hit, `res_addr` takes the real page number from PTE value bits [41:12] above the page offset. The low log2(page size) bits come from the lookup address.
- R7: PTE value bit 0 grants read and bit 1 grants write. A hit whose access direction (`lk_is_write`) is not granted raises `res_fault`. A miss never raises `res_fault`.
- R8: A PTE value write (`wr_kind`=1) clears the slot's valid flag. Lookups of that slot miss until a tag write makes it valid again.
- R9: A result appears on `res_valid` exactly two cycles after `lk_valid`. Back-to-back lookups give one result per cycle.
- R10: After reset, all segments and slots are invalid and `res_valid` is low.
- R11: A miss, including any lookup into an invalid segment, drives `res_hit`=0, `res_fault`=0 and `res_addr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Table write strobe |
| wr_kind | input | 2 | 0 segment, 1 PTE value, 2 PTE tag, 3 no-op |
| wr_idx | input | IDX_W | Segment number or PTE slot |
| wr_data | input | 64 | Write data |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | IO address to translate |
| lk_is_write | input | 1 | Lookup is for a write access |
| res_valid | output | 1 | Result valid |
| res_hit | output | 1 | Translation found |
| res_fault | output | 1 | Access not permitted |
| res_addr | output | 42 | Real address |

## Verification
The hardest case to reach from the ports is a lookup that lands in the window between a slot's value write and its tag write. The bench loads a translation, confirms that it hits, and rewrites only the value. It then looks the address up before restoring the tag. Tag mismatches need two addresses that hash to one slot with different tags. These arise from constrained-random preloads spread over segments of every page size, where later loads overwrite earlier ones. Those preloads are followed by back-to-back bursts that mix loaded and never-loaded addresses.

// File: rtl/itc_pkg.sv
package itc_pkg;
    localparam int IO_W   = 32;
    localparam int RA_W   = 42;
    localparam int PA_W   = 34;
    localparam int TAG_W  = 25;
    localparam int SEG_N  = 16;
    localparam int SEG_W  = $clog2(SEG_N);
    localparam int OFF_W  = 28;

    localparam logic [1:0] WK_SEG = 2'd0;
    localparam logic [1:0] WK_VAL = 2'd1;
    localparam logic [1:0] WK_TAG = 2'd2;

    typedef struct packed {
        logic        vld;
        logic [21:0] base;
        logic [2:0]  code;
    } seg_ent_t;
endpackage

// File: rtl/itc_seg_table.sv
module itc_seg_table
    import itc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SEG_W-1:0] w_idx,
    input  logic [63:0]      w_data,
    input  logic [SEG_W-1:0] r_idx,
    output seg_ent_t         r_ent
);
    seg_ent_t seg_d [SEG_N];
    seg_ent_t seg_q [SEG_N];

    logic unused_wbits;
    assign unused_wbits = ^{w_data[62:34], w_data[11:3]};

    always_comb begin
        seg_d = seg_q;
        if (we) begin
            seg_d[w_idx] = '{vld: w_data[63], base: w_data[33:12], code: w_data[2:0]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SEG_N; i++) seg_q[i] <= '0;
        end else begin
            seg_q <= seg_d;
        end
    end

    assign r_ent = seg_q[r_idx];
endmodule

// File: rtl/itc_addr_gen.sv
module itc_addr_gen
    import itc_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic [OFF_W-1:0] io_off,
    input  logic [21:0]      base,
    input  logic [2:0]       code,
    output logic [IDX_W-1:0] idx,
    output logic [TAG_W-1:0] tag,
    output logic [OFF_W-1:0] mask
);
    logic [4:0]       shift;
    logic [OFF_W-1:0] pnum;
    logic [18:0]      pofs;
    logic [PA_W-1:0]  pte;
    logic [5:0]       idx6;

    always_comb begin
        shift = 5'd10 + {1'b0, code, 1'b0};
        pnum  = io_off >> shift;
        mask  = (OFF_W'(1) << shift) - OFF_W'(1);
        pofs  = {pnum[15:0], 3'b000};
        pte   = {base, 12'h000} + {15'h0, pofs};
        idx6  = pte[8:3] ^ {pte[12], pte[13], pte[14], pte[15], pte[16], pte[17]};
        tag   = {pte[33:18], pte[11:3]};
    end

    logic unused_pte;
    assign unused_pte = ^{pte[2:0], pnum[OFF_W-1:16]};

    generate
        if (IDX_W == 8) begin : g_wide
            assign idx = {pte[15:14], idx6};
        end else begin : g_narrow
            assign idx = idx6;
        end
    endgenerate
endmodule

// File: rtl/itc_pte_store.sv
module itc_pte_store
    import itc_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             val_we,
    input  logic             tag_we,
    input  logic [IDX_W-1:0] w_idx,
    input  logic [63:0]      w_data,
    input  logic [IDX_W-1:0] r_idx,
    output logic [63:0]      r_val,
    output logic [TAG_W-1:0] r_tag,
    output logic             r_ok
);
    localparam int DEPTH = 1 << IDX_W;

    logic [63:0]      val_mem [DEPTH];
    logic [TAG_W-1:0] tag_mem [DEPTH];
    logic [DEPTH-1:0] ok_d, ok_q;

    logic unused_tbits;
    assign unused_tbits = ^w_data[63:26];

    // Payload arrays carry no reset; only the valid vector does.
    always_ff @(posedge clk) begin
        if (val_we) val_mem[w_idx] <= w_data;
        if (tag_we) tag_mem[w_idx] <= w_data[TAG_W-1:0];
    end

    always_comb begin
        ok_d = ok_q;
        if (val_we) ok_d[w_idx] = 1'b0;
        if (tag_we) ok_d[w_idx] = w_data[TAG_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ok_q <= '0;
        else        ok_q <= ok_d;
    end

    assign r_val = val_mem[r_idx];
    assign r_tag = tag_mem[r_idx];
    assign r_ok  = ok_q[r_idx];

    a_r8_value_write_drops_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (val_we && !tag_we) |=> !ok_q[$past(w_idx)]);
endmodule

// File: rtl/io_xlate_cache.sv
module io_xlate_cache
    import itc_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_kind,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [63:0]      wr_data,
    input  logic             lk_valid,
    input  logic [IO_W-1:0]  lk_addr,
    input  logic             lk_is_write,
    output logic             res_valid,
    output logic             res_hit,
    output logic             res_fault,
    output logic [RA_W-1:0]  res_addr
);
    typedef struct packed {
        logic             vld;
        logic             is_wr;
        logic             seg_ok;
        logic [IDX_W-1:0] idx;
        logic [TAG_W-1:0] tag;
        logic [OFF_W-1:0] mask;
        logic [OFF_W-1:0] ioff;
    } stage_t;

    typedef struct packed {
        logic            vld;
        logic            hit;
        logic            fault;
        logic [RA_W-1:0] addr;
    } result_t;

    stage_t   st_d, st_q;
    result_t  rs_d, rs_q;
    seg_ent_t seg;
    logic [IDX_W-1:0] ag_idx;
    logic [TAG_W-1:0] ag_tag;
    logic [OFF_W-1:0] ag_mask;
    logic [63:0]      pv;
    logic [TAG_W-1:0] ptag;
    logic             pok;

    itc_seg_table u_seg (
        .clk(clk), .rst_n(rst_n),
        .we(wr_en && wr_kind == WK_SEG),
        .w_idx(wr_idx[SEG_W-1:0]), .w_data(wr_data),
        .r_idx(lk_addr[IO_W-1:IO_W-SEG_W]), .r_ent(seg)
    );

    itc_addr_gen #(.IDX_W(IDX_W)) u_gen (
        .io_off(lk_addr[OFF_W-1:0]), .base(seg.base), .code(seg.code),
        .idx(ag_idx), .tag(ag_tag), .mask(ag_mask)
    );

    itc_pte_store #(.IDX_W(IDX_W)) u_pte (
        .clk(clk), .rst_n(rst_n),
        .val_we(wr_en && wr_kind == WK_VAL),
        .tag_we(wr_en && wr_kind == WK_TAG),
        .w_idx(wr_idx), .w_data(wr_data),
        .r_idx(st_q.idx), .r_val(pv), .r_tag(ptag), .r_ok(pok)
    );

    logic unused_pv;
    assign unused_pv = ^{pv[63:42], pv[11:2]};

    always_comb begin
        st_d = '{vld: lk_valid, is_wr: lk_is_write, seg_ok: seg.vld,
                 idx: ag_idx, tag: ag_tag, mask: ag_mask, ioff: lk_addr[OFF_W-1:0]};

        rs_d       = '0;
        rs_d.vld   = st_q.vld;
        rs_d.hit   = st_q.vld && st_q.seg_ok && pok && (ptag == st_q.tag);
        if (rs_d.hit) begin
            rs_d.fault = st_q.is_wr ? !pv[1] : !pv[0];
            rs_d.addr  = ({pv[41:12], 12'h000} & ~{14'h0, st_q.mask})
                       | {14'h0, st_q.ioff & st_q.mask};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
            rs_q <= '0;
        end else begin
            st_q <= st_d;
            rs_q <= rs_d;
        end
    end

    assign res_valid = rs_q.vld;
    assign res_hit   = rs_q.hit;
    assign res_fault = rs_q.fault;
    assign res_addr  = rs_q.addr;

    a_r9_two_cycle_result: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> ##1 res_valid);
    a_r7_fault_implies_hit: assert property (@(posedge clk) disable iff (!rst_n)
        res_fault |-> (res_hit && res_valid));
    a_r11_miss_is_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> (res_addr == '0 && !res_fault));
    a_r10_idle_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> !res_valid);
endmodule

// File: tb/io_xlate_cache_tb_top.sv
`timescale 1ns/1ps
module io_xlate_cache_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_kind = 2'd3;
    logic [7:0]  wr_idx = '0;
    logic [63:0] wr_data = '0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        lk_is_write = 1'b0;
    logic        res_valid, res_hit, res_fault;
    logic [41:0] res_addr;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    io_xlate_cache #(.IDX_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind),
        .wr_idx(wr_idx), .wr_data(wr_data), .lk_valid(lk_valid),
        .lk_addr(lk_addr), .lk_is_write(lk_is_write), .res_valid(res_valid),
        .res_hit(res_hit), .res_fault(res_fault), .res_addr(res_addr)
    );

    logic [63:0] seg_m [16];
    logic [63:0] val_m [256];
    logic [24:0] tag_m [256];
    bit          ok_m  [256];
    logic [31:0] loaded [64];
    int          n_loaded = 0;

    function automatic logic [33:0] pte_of(logic [31:0] a);
        logic [63:0] s = seg_m[a[31:28]];
        int sh = 10 + 2 * int'(s[2:0]);
        logic [27:0] pn = a[27:0] >> sh;
        logic [33:0] ofs = (34'(pn) << 3) & 34'h7fff8;
        return {s[33:12], 12'h000} + ofs;
    endfunction

    function automatic logic [7:0] idx_of(logic [33:0] p);
        logic [5:0] i6 = p[8:3] ^ {p[12], p[13], p[14], p[15], p[16], p[17]};
        return {p[15:14], i6};
    endfunction

    function automatic logic [24:0] tag_of(logic [33:0] p);
        return {p[33:18], p[11:3]};
    endfunction

    task automatic expect_of(input logic [31:0] a, input bit w,
                             output bit h, output bit f, output logic [41:0] ra);
        logic [33:0] p = pte_of(a);
        logic [7:0] i = idx_of(p);
        logic [63:0] s = seg_m[a[31:28]];
        int sh = 10 + 2 * int'(s[2:0]);
        logic [41:0] m = (42'd1 << sh) - 42'd1;
        h = s[63] && ok_m[i] && tag_m[i] == tag_of(p);
        f = h && (w ? !val_m[i][1] : !val_m[i][0]);
        ra = h ? (({val_m[i][41:12], 12'h000} & ~m) | (42'(a[27:0]) & m)) : '0;
    endtask

    task automatic check(input string req, input bit ok, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] k, input logic [7:0] i, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_kind = k; wr_idx = i; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_kind = 2'd3;
        case (k)
            2'd0: seg_m[i[3:0]] = d;
            2'd1: begin val_m[i] = d; ok_m[i] = 1'b0; end
            2'd2: begin tag_m[i] = d[24:0]; ok_m[i] = d[25]; end
            default: ;
        endcase
    endtask

    task automatic load(input logic [31:0] a, input logic [63:0] v);
        logic [33:0] p = pte_of(a);
        wr(2'd1, idx_of(p), v);
        wr(2'd2, idx_of(p), {38'h0, 1'b1, tag_of(p)});
        if (n_loaded < 64) begin loaded[n_loaded] = a; n_loaded++; end
    endtask

    task automatic look1(input logic [31:0] a, input bit w, input string req);
        bit h, f; logic [41:0] ra;
        expect_of(a, w, h, f, ra);
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = a; lk_is_write = w;
        @(negedge clk);
        lk_valid = 1'b0;
        @(negedge clk);
        check({req, " valid"}, res_valid === 1'b1, 64'(res_valid), 64'd1);
        check({req, " hit"}, res_hit === h, 64'(res_hit), 64'(h));
        check({req, " fault"}, res_fault === f, 64'(res_fault), 64'(f));
        check({req, " addr"}, res_addr === ra, 64'(res_addr), 64'(ra));
    endtask

    task automatic burst(input int n);
        bit eh [64]; bit ef [64]; logic [41:0] ea [64];
        for (int i = 0; i < n + 2; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                check("R9 back-to-back valid", res_valid === 1'b1, 64'(res_valid), 64'd1);
                check("R4 hit", res_hit === eh[i-2], 64'(res_hit), 64'(eh[i-2]));
                check("R7 fault", res_fault === ef[i-2], 64'(res_fault), 64'(ef[i-2]));
                check("R6 addr", res_addr === ea[i-2], 64'(res_addr), 64'(ea[i-2]));
            end
            if (i < n) begin
                logic [31:0] a;
                bit w = 1'($urandom);
                if (($urandom % 10) < 7 && n_loaded > 0) a = loaded[$urandom % n_loaded];
                else a = $urandom;
                expect_of(a, w, eh[i], ef[i], ea[i]);
                lk_valid = 1'b1; lk_addr = a; lk_is_write = w;
            end else begin
                lk_valid = 1'b0;
            end
        end
    endtask

    initial begin
        #(200000 * 5);
        bad++; total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 16; i++) seg_m[i] = '0;
        for (int i = 0; i < 256; i++) begin val_m[i] = '0; tag_m[i] = '0; ok_m[i] = 1'b0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 res_valid after reset", res_valid === 1'b0, 64'(res_valid), 64'd0);
        look1(32'h1234_5678, 1'b0, "R10 lookup before any load misses");

        // Segments: size codes 1,3,5,7 in turn; segment 9 left invalid.
        for (int s = 0; s < 16; s++) begin
            logic [2:0] c = 3'(2 * (s % 4) + 1);
            logic [21:0] b = 22'($urandom);
            if (s != 9) wr(2'd0, 8'(s), {1'b1, 29'h0, b, 9'h0, c});
        end
        look1(32'h9000_0000, 1'b0, "R11 invalid segment");

        // R7: read-only page, then write-only page.
        load(32'h3012_3456, {22'h0, 30'h2aa_5555, 10'h0, 2'b01});
        look1(32'h3012_3456, 1'b0, "R7 read allowed");
        look1(32'h3012_3456, 1'b1, "R7 write denied");
        load(32'h2040_0010, {22'h0, 30'h155_aaaa, 10'h0, 2'b10});
        look1(32'h2040_0010, 1'b0, "R7 read denied");
        look1(32'h2040_0010, 1'b1, "R7 write allowed");

        // R2/R6: 4 KB page in segment 0 and 16 MB page in segment 3 with top offset.
        load(32'h0abc_dfff, {22'h0, 30'h3fff_ffff, 10'h0, 2'b11});
        look1(32'h0abc_dfff, 1'b0, "R2 R6 4KB translation");
        load(32'h3fff_fffe, {22'h0, 30'h1234_5678, 10'h0, 2'b11});
        look1(32'h3fff_fffe, 1'b1, "R2 R3 R6 16MB translation");

        // R8: value rewrite without tag leaves slot missing until tag returns.
        begin
            logic [33:0] p = pte_of(32'h0abc_dfff);
            wr(2'd1, idx_of(p), {22'h0, 30'h0bad_0bad, 10'h0, 2'b11});
            look1(32'h0abc_dfff, 1'b0, "R8 miss between value and tag");
            wr(2'd2, idx_of(p), {38'h0, 1'b1, tag_of(p)});
            look1(32'h0abc_dfff, 1'b0, "R8 hit after tag with new value");
        end

        // Random preloads across all page sizes (R1 R3 R5), then bursts.
        for (int k = 0; k < 40; k++) begin
            logic [31:0] a = $urandom;
            logic [63:0] v = {$urandom, $urandom};
            load(a, v);
        end
        for (int b = 0; b < 8; b++) burst(40);
        for (int k = 0; k < 20; k++) look1($urandom, 1'($urandom), "R1 R4 R5 random single");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule